// File: doc/BRIEF.md
# Error Report Capture with Dual Serial Readout

This block takes an error report produced by a configuration-memory scrubber and stores it as one 67-bit word. The scrubber presents the report as six separate fields together with a one-cycle valid strobe. The block packs those fields into a capture register. It then hands the word to two readout paths that run independently of each other. Path 0 serves a debug serial port and path 1 serves on-chip user logic.

Each readout path has two registers. The staging register takes the captured word one cycle after the valid strobe. The serial register loads the whole staging register in parallel when its load strobe is pulsed, then shifts the word out least significant bit first. While a path is shifting, its staging register is frozen. A report that arrives during the shift waits in the capture register and is staged on the first idle cycle. Each path has a sticky flag that records any report lost before it was transferred.

The block also holds the 32-bit CRC signature of the frame being checked. It raises an error output whenever that signature is nonzero. Each path runs a two-state controller. In ST_IDLE, a load strobe takes the "start" transition to ST_SHIFT. In ST_SHIFT, each shift enable takes the "step" transition, and the step that completes the word takes the "finish" transition back to ST_IDLE.

Top module: `errmsg_readout`

## Requirements
- R1: The captured word is {syndrome[31:0], frame[15:0], dword[9:0], byte[1:0], bit[2:0], type[3:0]}, with the syndrome at the most significant end (bits 66..35) and the type at bits 3..0. The serial output presents word bit k after k shift steps.
- R2: A sig_valid pulse loads sig_value into the signature register. From the next clock edge on, crc_err is 1 when the stored value is nonzero and 0 when it is zero. Without sig_valid, crc_err holds its value.
- R3: Every msg_valid pulse overwrites the capture register. When several reports arrive before a path takes one, that path later delivers the most recent report.
- R4: A staging register takes a new report at the clock edge after the edge that captured it. A load strobe at that same edge therefore transfers the previous report, and a load strobe one edge later transfers the new one.
- R5: A load strobe while ST_IDLE copies the staging register into the serial register and raises rd_busy. rd_sout then shows word bit 0.
- R6: Each shift enable in ST_SHIFT advances one bit. After 67 shift steps, rd_busy falls. A load strobe during ST_SHIFT has no effect on the bits shifted out.
- R7: During ST_SHIFT the staging register does not change. A report that arrives during the shift is staged on the first ST_IDLE cycle, so the next readout delivers it.
- R8: rd_ovf is set when a report replaces a staged report that was never transferred, or replaces a report still waiting from a shift. Once set, it stays set until reset.
- R9: The two paths are independent. Loading, shifting or overflow on one path leaves the other path's output word and flag unaffected.
- R10: Reset clears all registers. After reset, crc_err, rd_busy, rd_sout and rd_ovf are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_valid | input | 1 | Report valid strobe |
| msg_syndrome | input | 32 | Syndrome field |
| msg_frame | input | 16 | Frame address field |
| msg_dword | input | 10 | Double-word location field |
| msg_byte | input | 2 | Byte offset field |
| msg_bit | input | 3 | Bit offset field |
| msg_type | input | 4 | Error type field |
| sig_valid | input | 1 | Signature load strobe |
| sig_value | input | 32 | CRC signature of the current frame |
| crc_err | output | 1 | High when the stored signature is nonzero |
| rd_load | input | NPATH | Per-path transfer strobe (0 = debug, 1 = user) |
| rd_shift | input | NPATH | Per-path shift enable |
| rd_sout | output | NPATH | Per-path serial data, least significant bit first |
| rd_busy | output | NPATH | Per-path shift in progress |
| rd_ovf | output | NPATH | Per-path sticky lost-report flag |

## Verification
Several properties are checked on every cycle:
- the field packing into the capture register and the hold of that register between strobes;
- the signature-to-error relation;
- the one-edge staging latency whenever a path is idle and not loading;
- the freeze of the staging register during a shift;
- the first bit presented at the start of a shift;
- the stickiness of the overflow flag.

Other behaviour only shows up in the bench's scenarios. This covers the exact 67-step length of a shift, a report that arrives mid-shift being deferred and then delivered, the boundary between a load at the staging edge and one edge later, overflow on one path while the other stays clean, and the latest report winning after several arrive.

// File: rtl/errmsg_pkg.sv
`timescale 1ns/1ps
package errmsg_pkg;
    localparam int SYN_W = 32;
    localparam int FRM_W = 16;
    localparam int DWL_W = 10;
    localparam int BYT_W = 2;
    localparam int BIT_W = 3;
    localparam int TYP_W = 4;
    localparam int MSG_W = SYN_W + FRM_W + DWL_W + BYT_W + BIT_W + TYP_W;
    localparam int CNT_W = $clog2(MSG_W);
    localparam int SIG_W = 32;

    // first member lands at the most significant end
    typedef struct packed {
        logic [SYN_W-1:0] syndrome;
        logic [FRM_W-1:0] frame;
        logic [DWL_W-1:0] dword;
        logic [BYT_W-1:0] byte_off;
        logic [BIT_W-1:0] bit_off;
        logic [TYP_W-1:0] etype;
    } emr_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } rd_state_e;
endpackage

// File: rtl/errmsg_capture.sv
`timescale 1ns/1ps
module errmsg_capture
    import errmsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [SYN_W-1:0] syndrome_i,
    input  logic [FRM_W-1:0] frame_i,
    input  logic [DWL_W-1:0] dword_i,
    input  logic [BYT_W-1:0] byte_i,
    input  logic [BIT_W-1:0] bit_i,
    input  logic [TYP_W-1:0] type_i,
    output logic [MSG_W-1:0] emr_o,
    output logic             tick_o
);
    emr_t emr_d;
    emr_t emr_q;
    logic tick_q;

    always_comb begin
        emr_d.syndrome = syndrome_i;
        emr_d.frame    = frame_i;
        emr_d.dword    = dword_i;
        emr_d.byte_off = byte_i;
        emr_d.bit_off  = bit_i;
        emr_d.etype    = type_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            emr_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= valid_i;
            if (valid_i) begin
                emr_q <= emr_d;
            end
        end
    end

    assign emr_o  = emr_q;
    assign tick_o = tick_q;
endmodule

// File: rtl/errmsg_sig_reg.sv
`timescale 1ns/1ps
module errmsg_sig_reg
    import errmsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [SIG_W-1:0] value_i,
    output logic             err_o
);
    logic [SIG_W-1:0] sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= '0;
        end else if (load_i) begin
            sig_q <= value_i;
        end
    end

    assign err_o = |sig_q;
endmodule

// File: rtl/errmsg_readout_path.sv
`timescale 1ns/1ps
module errmsg_readout_path
    import errmsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MSG_W-1:0] emr_i,
    input  logic             tick_i,
    input  logic             ld_en_i,
    input  logic             sh_en_i,
    output logic             so_o,
    output logic             busy_o,
    output logic             ovf_o,
    output logic [MSG_W-1:0] upd_o
);
    rd_state_e        state_q, state_d;
    logic [MSG_W-1:0] upd_q;
    logic [MSG_W-1:0] shr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             held_q;
    logic             defer_q;
    logic             ovf_q;
    logic             start, step;
    logic             pend;

    assign pend = tick_i | defer_q;

    // next-state decode
    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        step    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ld_en_i) begin
                    start   = 1'b1;
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (sh_en_i) begin
                    step = 1'b1;
                    if (cnt_q == CNT_W'(MSG_W - 1)) begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // staging, serial and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_q   <= '0;
            shr_q   <= '0;
            cnt_q   <= '0;
            held_q  <= 1'b0;
            defer_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            if (start) begin
                shr_q   <= upd_q;
                cnt_q   <= '0;
                held_q  <= 1'b0;
                defer_q <= pend;
                if (defer_q && tick_i) begin
                    ovf_q <= 1'b1;
                end
            end else if (pend) begin
                upd_q   <= emr_i;
                held_q  <= 1'b1;
                defer_q <= 1'b0;
                if (held_q || (defer_q && tick_i)) begin
                    ovf_q <= 1'b1;
                end
            end
        end else begin
            if (step) begin
                shr_q <= shr_q >> 1;
                cnt_q <= cnt_q + 1'b1;
            end
            if (tick_i) begin
                defer_q <= 1'b1;
                if (defer_q) begin
                    ovf_q <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        so_o   = shr_q[0];
        busy_o = (state_q == ST_SHIFT);
        ovf_o  = ovf_q;
        upd_o  = upd_q;
    end
endmodule

// File: rtl/errmsg_readout.sv
`timescale 1ns/1ps
module errmsg_readout
    import errmsg_pkg::*;
#(
    parameter int NPATH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_valid,
    input  logic [SYN_W-1:0] msg_syndrome,
    input  logic [FRM_W-1:0] msg_frame,
    input  logic [DWL_W-1:0] msg_dword,
    input  logic [BYT_W-1:0] msg_byte,
    input  logic [BIT_W-1:0] msg_bit,
    input  logic [TYP_W-1:0] msg_type,
    input  logic             sig_valid,
    input  logic [SIG_W-1:0] sig_value,
    output logic             crc_err,
    input  logic [NPATH-1:0] rd_load,
    input  logic [NPATH-1:0] rd_shift,
    output logic [NPATH-1:0] rd_sout,
    output logic [NPATH-1:0] rd_busy,
    output logic [NPATH-1:0] rd_ovf
);
    logic [MSG_W-1:0]            emr_q;
    logic                        emr_tick;
    logic [NPATH-1:0][MSG_W-1:0] upd_word;

    errmsg_capture u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (msg_valid),
        .syndrome_i (msg_syndrome),
        .frame_i    (msg_frame),
        .dword_i    (msg_dword),
        .byte_i     (msg_byte),
        .bit_i      (msg_bit),
        .type_i     (msg_type),
        .emr_o      (emr_q),
        .tick_o     (emr_tick)
    );

    errmsg_sig_reg u_sig (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sig_valid),
        .value_i (sig_value),
        .err_o   (crc_err)
    );

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        errmsg_readout_path u_path (
            .clk     (clk),
            .rst_n   (rst_n),
            .emr_i   (emr_q),
            .tick_i  (emr_tick),
            .ld_en_i (rd_load[g]),
            .sh_en_i (rd_shift[g]),
            .so_o    (rd_sout[g]),
            .busy_o  (rd_busy[g]),
            .ovf_o   (rd_ovf[g]),
            .upd_o   (upd_word[g])
        );
    end
endmodule

// File: rtl/errmsg_readout_chk.sv
`timescale 1ns/1ps
module errmsg_readout_chk
    import errmsg_pkg::*;
#(
    parameter int NPATH = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        msg_valid,
    input logic [SYN_W-1:0]            msg_syndrome,
    input logic [FRM_W-1:0]            msg_frame,
    input logic [DWL_W-1:0]            msg_dword,
    input logic [BYT_W-1:0]            msg_byte,
    input logic [BIT_W-1:0]            msg_bit,
    input logic [TYP_W-1:0]            msg_type,
    input logic                        sig_valid,
    input logic [SIG_W-1:0]            sig_value,
    input logic                        crc_err,
    input logic [NPATH-1:0]            rd_load,
    input logic [NPATH-1:0]            rd_sout,
    input logic [NPATH-1:0]            rd_busy,
    input logic [NPATH-1:0]            rd_ovf,
    input logic [MSG_W-1:0]            emr_q,
    input logic                        emr_tick,
    input logic [NPATH-1:0][MSG_W-1:0] upd_word
);
    p_emr_pack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(msg_valid) |-> emr_q == {$past(msg_syndrome), $past(msg_frame), $past(msg_dword),
                                       $past(msg_byte), $past(msg_bit), $past(msg_type)})
        else $error("p_emr_pack_r1");

    p_emr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(msg_valid) |-> $stable(emr_q))
        else $error("p_emr_hold_r3");

    p_crc_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sig_valid) |-> crc_err == ($past(sig_value) != '0))
        else $error("p_crc_err_r2");

    p_crc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sig_valid) |-> $stable(crc_err))
        else $error("p_crc_hold_r2");

    for (genvar g = 0; g < NPATH; g++) begin : g_chk
        p_upd_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(emr_tick) && !$past(rd_busy[g]) && !$past(rd_load[g]))
                |-> upd_word[g] == $past(emr_q))
            else $error("p_upd_latency_r4");

        p_upd_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rd_busy[g]) |-> $stable(upd_word[g]))
            else $error("p_upd_frozen_r7");

        p_load_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rd_busy[g]) |-> ($past(rd_load[g]) && rd_sout[g] == $past(upd_word[g][0])))
            else $error("p_load_start_r5");

        p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rd_ovf[g]) |-> rd_ovf[g])
            else $error("p_ovf_sticky_r8");
    end
endmodule

bind errmsg_readout errmsg_readout_chk #(.NPATH(NPATH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .msg_valid    (msg_valid),
    .msg_syndrome (msg_syndrome),
    .msg_frame    (msg_frame),
    .msg_dword    (msg_dword),
    .msg_byte     (msg_byte),
    .msg_bit      (msg_bit),
    .msg_type     (msg_type),
    .sig_valid    (sig_valid),
    .sig_value    (sig_value),
    .crc_err      (crc_err),
    .rd_load      (rd_load),
    .rd_sout      (rd_sout),
    .rd_busy      (rd_busy),
    .rd_ovf       (rd_ovf),
    .emr_q        (emr_q),
    .emr_tick     (emr_tick),
    .upd_word     (upd_word)
);

// File: tb/test_errmsg_readout.sv
`timescale 1ns/1ps
module test_errmsg_readout;
    localparam int MW = 67;
    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          msg_valid = 1'b0;
    logic [31:0]   msg_syndrome = '0;
    logic [15:0]   msg_frame = '0;
    logic [9:0]    msg_dword = '0;
    logic [1:0]    msg_byte = '0;
    logic [2:0]    msg_bit = '0;
    logic [3:0]    msg_type = '0;
    logic          sig_valid = 1'b0;
    logic [31:0]   sig_value = '0;
    logic          crc_err;
    logic [NP-1:0] rd_load = '0;
    logic [NP-1:0] rd_shift = '0;
    logic [NP-1:0] rd_sout;
    logic [NP-1:0] rd_busy;
    logic [NP-1:0] rd_ovf;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    errmsg_readout #(.NPATH(NP)) i_errmsg_readout (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid),
        .msg_syndrome(msg_syndrome), .msg_frame(msg_frame), .msg_dword(msg_dword),
        .msg_byte(msg_byte), .msg_bit(msg_bit), .msg_type(msg_type),
        .sig_valid(sig_valid), .sig_value(sig_value), .crc_err(crc_err),
        .rd_load(rd_load), .rd_shift(rd_shift), .rd_sout(rd_sout),
        .rd_busy(rd_busy), .rd_ovf(rd_ovf)
    );

    function automatic logic [MW-1:0] pack(input logic [31:0] s, input logic [15:0] f,
        input logic [9:0] d, input logic [1:0] b, input logic [2:0] t, input logic [3:0] e);
        return {s, f, d, b, t, e};
    endfunction

    function automatic logic [MW-1:0] rand_msg();
        return pack($urandom(), 16'($urandom()), 10'($urandom()), 2'($urandom()),
                    3'($urandom()), 4'($urandom()));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [MW-1:0] act, input logic [MW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic put_msg(input logic [MW-1:0] m);
        msg_valid    = 1'b1;
        msg_syndrome = m[66:35];
        msg_frame    = m[34:19];
        msg_dword    = m[18:9];
        msg_byte     = m[8:7];
        msg_bit      = m[6:4];
        msg_type     = m[3:0];
    endtask

    task automatic send_msg(input logic [MW-1:0] m);
        put_msg(m);
        step();
        msg_valid = 1'b0;
    endtask

    // load path p, shift the full word out, compare against exp
    task automatic read_path(input int p, input logic [MW-1:0] exp,
                             input bit pre_on, input logic [MW-1:0] pre_msg,
                             input int inj_a, input logic [MW-1:0] msg_a,
                             input int inj_b, input logic [MW-1:0] msg_b,
                             input int ld_at, input string req);
        logic [MW-1:0] got;
        got = '0;
        if (pre_on) send_msg(pre_msg);
        rd_load[p] = 1'b1;
        step();
        rd_load[p] = 1'b0;
        check(rd_busy[p] == 1'b1, "R5", "busy after load", MW'(rd_busy[p]), MW'(1));
        for (int k = 0; k < MW; k++) begin
            got[k] = rd_sout[p];
            rd_shift[p] = 1'b1;
            if (k == inj_a) put_msg(msg_a);
            if (k == inj_b) put_msg(msg_b);
            if (k == ld_at) rd_load[p] = 1'b1;
            step();
            rd_shift[p] = 1'b0;
            rd_load[p]  = 1'b0;
            msg_valid   = 1'b0;
        end
        check(got == exp, req, "serial word", got, exp);
        check(rd_busy[p] == 1'b0, "R6", "idle after 67 shifts", MW'(rd_busy[p]), MW'(0));
    endtask

    task automatic sig_check(input logic [31:0] v);
        sig_valid = 1'b1;
        sig_value = v;
        step();
        sig_valid = 1'b0;
        check(crc_err == (v != 0), "R2", "crc_err after load", MW'(crc_err), MW'(v != 0));
    endtask

    initial begin
        #1000000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [MW-1:0] m1, m2, ma, mb, mc, md, me;
        logic          prev;
        int            inj;
        void'($urandom(32'd7713));

        step(); step();
        check(crc_err == 0 && rd_busy == 0 && rd_sout == 0 && rd_ovf == 0, "R10",
              "outputs in reset", MW'({crc_err, rd_busy, rd_sout, rd_ovf}), MW'(0));
        rst_n = 1'b1;
        step();

        // R2 signature to error output
        sig_check(32'h0000_0000);
        sig_check(32'h8000_0000);
        sig_check(32'h0000_0000);
        sig_check(32'h0000_0001);
        prev = crc_err;
        sig_value = 32'h0;
        step();
        check(crc_err == prev, "R2", "hold without strobe", MW'(crc_err), MW'(prev));
        for (int i = 0; i < 6; i++) sig_check((i % 3 == 0) ? 32'h0 : $urandom());

        // R1 directed packing: syndrome LSB at bit 35, type MSB at bit 3
        m1 = pack(32'h0000_0001, 16'h8001, 10'h201, 2'b10, 3'b101, 4'b1000);
        send_msg(m1); step();
        read_path(1, m1, 0, '0, -1, '0, -1, '0, -1, "R1");
        read_path(0, m1, 0, '0, -1, '0, -1, '0, -1, "R1");

        // random reports, readout on both paths, mid-shift arrivals
        for (int it = 0; it < 10; it++) begin
            m1 = rand_msg();
            m2 = rand_msg();
            send_msg(m1); step();
            read_path(1, m1, 0, '0, -1, '0, -1, '0, -1, "R9");
            inj = ($urandom() % 2 == 1) ? int'($urandom() % MW) : -1;
            if (it == 2) inj = MW - 1;
            if (it == 3) inj = MW - 2;
            read_path(0, m1, 0, '0, inj, m2, -1, '0, (it == 4) ? 30 : -1,
                      (it == 4) ? "R6" : "R7");
            if (inj >= 0) begin
                step(); step();
                read_path(0, m2, 0, '0, -1, '0, -1, '0, -1, "R7");
                read_path(1, m2, 0, '0, -1, '0, -1, '0, -1, "R9");
            end
        end
        check(rd_ovf == 0, "R8", "no loss flagged", MW'(rd_ovf), MW'(0));

        // R4 latency boundary on path 0
        ma = rand_msg(); mb = rand_msg(); mc = rand_msg();
        send_msg(ma); step();
        read_path(0, ma, 1, mb, -1, '0, -1, '0, -1, "R4");
        step(); step();
        read_path(0, mb, 0, '0, -1, '0, -1, '0, -1, "R7");
        send_msg(mc); step();
        read_path(0, mc, 0, '0, -1, '0, -1, '0, -1, "R4");
        check(rd_ovf == 2'b10, "R9", "overflow only on unread path", MW'(rd_ovf), MW'(2'b10));

        // R8 two arrivals during one shift, R3 latest wins
        md = rand_msg(); me = rand_msg();
        read_path(0, mc, 0, '0, 10, md, 20, me, -1, "R7");
        check(rd_ovf[0] == 1'b1, "R8", "deferred report lost", MW'(rd_ovf[0]), MW'(1));
        step(); step();
        read_path(0, me, 0, '0, -1, '0, -1, '0, -1, "R3");
        read_path(1, me, 0, '0, -1, '0, -1, '0, -1, "R3");
        check(rd_ovf == 2'b11, "R8", "flags stay set", MW'(rd_ovf), MW'(2'b11));

        // R10 reset clears everything
        sig_check(32'hdead_beef);
        rst_n = 1'b0;
        step();
        check(crc_err == 0 && rd_busy == 0 && rd_sout == 0 && rd_ovf == 0, "R10",
              "outputs after reset", MW'({crc_err, rd_busy, rd_sout, rd_ovf}), MW'(0));
        rst_n = 1'b1;
        step();
        read_path(0, '0, 0, '0, -1, '0, -1, '0, -1, "R10");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule